// File: doc/BRIEF.md
# Pin identification waveform generator

This block drives each output line of a pin bank with its own repeating pattern. Someone probing a board with an oscilloscope can then tell which physical pin carries which logical index, with no other equipment. Every frame is read by eye from left to right. First comes a short burst of one-clock spikes, one at the start of each time step, so the viewer can see how long a time step is. Next comes a low guard step, then a long high marker. After the marker, the pin's own index is sent in binary, one bit per time step, followed by a closing low guard step.

All lanes run from one shared step timer and one shared frame sequencer, so the frames on every pin start together. Only the index field differs from pin to pin. The number of lanes and the length of a time step in system clocks are parameters.

Top module: `pinid_wavegen`

## Requirements
- R1: While reset is asserted, and in the clock after each edge that samples reset high, every output line is low.
- R2: A frame begins with 4 spike steps. In each of these steps every line is high for the first system clock only and low for the rest of the step.
- R3: The step after the spikes (step 4 of the frame) is a low guard step on every line.
- R4: Frame steps 5 to 12, eight steps in total, are held high on every line.
- R5: Frame steps 13 to 20 carry the lane's 8-bit index, least significant bit first. Step 13+k holds bit k for the whole step. Lane 71 is therefore high in steps 13, 14, 15 and 19 and low in the other four.
- R6: Frame step 21 is a low guard step. A frame lasts 22 steps, and the next frame follows at once with its spikes.
- R7: All lanes share one frame position, so outside the index field every line holds the same value.
- R8: A reset applied in the middle of a frame restarts the pattern from the first spike step. The first clock after the reset edge shows frame position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pins_o | output | NUM_PINS | One identification waveform per lane, bit i for lane i |

## Verification
Every lane's output is compared on every clock against a behavioural model of the frame position. This shows whether spikes, guards, marker and index field fall in the right steps and whether spikes last exactly one clock. Each lane's index is also decoded from the sampled index field alone, separately from the model. This catches bit order, bit weight and lane-to-index mapping errors; lane 71 is the worked example. A reset asserted in mid-frame shows that the outputs drop low and that the sequence restarts at the first spike rather than carrying on from where it stopped.

// File: rtl/pinid_pkg.sv
package pinid_pkg;

   typedef enum logic [1:0] {
      PH_PRE   = 2'd0,
      PH_GUARD = 2'd1,
      PH_MARK  = 2'd2,
      PH_DATA  = 2'd3
   } phase_t;

   localparam int SPIKE_STEPS = 4;
   localparam int MARK_STEPS  = 8;
   localparam int IDX_BITS    = 8;

   // Frame layout in steps: spikes, guard, marker, index, guard
   localparam int MARK_FIRST  = SPIKE_STEPS + 1;
   localparam int DATA_FIRST  = MARK_FIRST + MARK_STEPS;
   localparam int TAIL_STEP   = DATA_FIRST + IDX_BITS;
   localparam int FRAME_STEPS = TAIL_STEP + 1;

endpackage

// File: rtl/pinid_step_timer.sv
module pinid_step_timer #(
   parameter int STEP_CYCLES = 4
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic step_first_o,
   output logic step_end_o
);
   localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

   logic [CW-1:0] cyc_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cyc_q <= '0;
      end else if (cyc_q == LAST) begin
         cyc_q <= '0;
      end else begin
         cyc_q <= cyc_q + 1'b1;
      end
   end

   assign step_first_o = (cyc_q == '0);
   assign step_end_o   = (cyc_q == LAST);
endmodule

// File: rtl/pinid_frame_seq.sv
module pinid_frame_seq
   import pinid_pkg::*;
#(
   parameter int FRAME_LEN = FRAME_STEPS
) (
   input  logic                        clk_i,
   input  logic                        rst_i,
   input  logic                        step_end_i,
   output phase_t                      phase_o,
   output logic [$clog2(IDX_BITS)-1:0] bit_sel_o
);
   localparam int SW = $clog2(FRAME_LEN);
   localparam int BW = $clog2(IDX_BITS);
   localparam logic [SW-1:0] STEP_LAST = SW'(FRAME_LEN - 1);

   logic [SW-1:0] step_q;
   logic [SW-1:0] data_off;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         step_q <= '0;
      end else if (step_end_i) begin
         step_q <= (step_q == STEP_LAST) ? '0 : step_q + 1'b1;
      end
   end

   always_comb begin
      if (step_q < SW'(SPIKE_STEPS)) begin
         phase_o = PH_PRE;
      end else if (step_q < SW'(MARK_FIRST)) begin
         phase_o = PH_GUARD;
      end else if (step_q < SW'(DATA_FIRST)) begin
         phase_o = PH_MARK;
      end else if (step_q < SW'(TAIL_STEP)) begin
         phase_o = PH_DATA;
      end else begin
         phase_o = PH_GUARD;
      end
   end

   assign data_off  = step_q - SW'(DATA_FIRST);
   assign bit_sel_o = data_off[BW-1:0];
endmodule

// File: rtl/pinid_lane.sv
module pinid_lane
   import pinid_pkg::*;
#(
   parameter logic [IDX_BITS-1:0] PIN_IDX = '0
) (
   input  logic                        clk_i,
   input  logic                        rst_i,
   input  phase_t                      phase_i,
   input  logic                        step_first_i,
   input  logic [$clog2(IDX_BITS)-1:0] bit_sel_i,
   output logic                        pin_o
);
   logic level_d;

   always_comb begin
      unique case (phase_i)
         PH_PRE:   level_d = step_first_i;
         PH_MARK:  level_d = 1'b1;
         PH_DATA:  level_d = PIN_IDX[bit_sel_i];
         default:  level_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pin_o <= 1'b0;
      end else begin
         pin_o <= level_d;
      end
   end
endmodule

// File: rtl/pinid_wavegen.sv
module pinid_wavegen
   import pinid_pkg::*;
#(
   parameter int NUM_PINS    = 16,
   parameter int STEP_CYCLES = 4
) (
   input  logic                clk_i,
   input  logic                rst_i,
   output logic [NUM_PINS-1:0] pins_o
);
   localparam int BW = $clog2(IDX_BITS);

   if (STEP_CYCLES < 2) begin : g_bad_step
      $error("STEP_CYCLES must be at least 2 so a spike is narrower than a step");
   end
   if (NUM_PINS < 1 || NUM_PINS > (1 << IDX_BITS)) begin : g_bad_pins
      $error("NUM_PINS must lie between 1 and 2**IDX_BITS");
   end

   logic          step_first;
   logic          step_end;
   phase_t        phase;
   logic [BW-1:0] bit_sel;

   pinid_step_timer #(
      .STEP_CYCLES (STEP_CYCLES)
   ) u_timer (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .step_first_o (step_first),
      .step_end_o   (step_end)
   );

   pinid_frame_seq #(
      .FRAME_LEN (FRAME_STEPS)
   ) u_seq (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .step_end_i (step_end),
      .phase_o    (phase),
      .bit_sel_o  (bit_sel)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_lane
      pinid_lane #(
         .PIN_IDX (IDX_BITS'(i))
      ) u_lane (
         .clk_i        (clk_i),
         .rst_i        (rst_i),
         .phase_i      (phase),
         .step_first_i (step_first),
         .bit_sel_i    (bit_sel),
         .pin_o        (pins_o[i])
      );
   end
endmodule

// File: rtl/pinid_wavegen_chk.sv
module pinid_wavegen_chk
   import pinid_pkg::*;
#(
   parameter int NUM_PINS = 16
) (
   input logic                clk,
   input logic                rst,
   input logic [NUM_PINS-1:0] pins,
   input phase_t              phase,
   input logic                step_first
);
   // R1: outputs low after an edge that sees reset
   a_r1_reset_low: assert property (@(posedge clk)
      rst |=> (pins == '0));

   // R2: spike occupies only the first clock of a preamble step
   a_r2_spike_high: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_PRE && step_first) |=> (pins == '1));
   a_r2_spike_narrow: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_PRE && !step_first) |=> (pins == '0));

   // R3 and R6: guard steps are low
   a_r3_guard_low: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_GUARD) |=> (pins == '0));

   // R4: marker is high on every lane
   a_r4_marker_high: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_MARK) |=> (pins == '1));

   // R7: lanes agree outside the index field
   a_r7_aligned: assert property (@(posedge clk) disable iff (rst)
      (phase != PH_DATA) |=> (pins == '0 || pins == '1));
endmodule

bind pinid_wavegen pinid_wavegen_chk #(
   .NUM_PINS (NUM_PINS)
) u_chk (
   .clk        (clk_i),
   .rst        (rst_i),
   .pins       (pins_o),
   .phase      (phase),
   .step_first (step_first)
);

// File: tb/pinid_wavegen_tb.sv
`timescale 1ns/1ps
module pinid_wavegen_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 80;
   localparam int SC = 3;
   localparam int FRAME = 22 * SC;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [NP-1:0] pins;

   int total = 0;
   int bad   = 0;
   int pos   = 0;
   bit r8_mode = 1'b0;
   bit done  = 1'b0;
   int dec [NP];

   pinid_wavegen #(.NUM_PINS(NP), .STEP_CYCLES(SC)) u_dut (
      .clk_i  (clk),
      .rst_i  (rst),
      .pins_o (pins)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic bit exp_bit(int pin, int p);
      int q  = p % FRAME;
      int st = q / SC;
      int c  = q % SC;
      if (st < 4)  return (c == 0);
      if (st == 4) return 1'b0;
      if (st < 13) return 1'b1;
      if (st < 21) return 1'((pin >> (st - 13)) & 1);
      return 1'b0;
   endfunction

   function automatic string tag_of(int p);
      int st = (p % FRAME) / SC;
      if (st < 4)  return "R2";
      if (st == 4) return "R3";
      if (st < 13) return "R4";
      if (st < 21) return "R5";
      return "R6";
   endfunction

   task automatic check_vec(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s pos=%0d act=%h exp=%h", tag, pos, act, exp);
      end
   endtask

   // one clock: posedge, sample at negedge, compare with the model
   task automatic tick_check();
      logic [NP-1:0] e;
      int q;
      @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < NP; i++) e[i] = exp_bit(i, pos);
      check_vec((r8_mode && pos < FRAME) ? "R8" : tag_of(pos), pins, e);
      q = pos % FRAME;
      if (q % SC == 0 && q / SC >= 13 && q / SC < 21)
         for (int i = 0; i < NP; i++)
            if (pins[i]) dec[i] += (1 << (q / SC - 13));
      pos++;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_vec("R1", pins, '0);
      rst = 1'b0;
      pos = 0;
      for (int i = 0; i < NP; i++) dec[i] = 0;
      for (int k = 0; k < FRAME; k++) tick_check();
      // R5 and R7: decode each lane's index from its own waveform
      for (int i = 0; i < NP; i++) begin
         total++;
         if (dec[i] != i) begin
            bad++;
            $display("FAIL R5 lane=%0d act=%0d exp=%0d", i, dec[i], i);
         end
      end
      for (int k = 0; k < FRAME + FRAME / 2 + 1; k++) tick_check();
      // R8: reset in mid-frame
      rst = 1'b1;
      repeat (2) begin
         @(posedge clk); @(negedge clk);
         check_vec("R1", pins, '0);
      end
      rst = 1'b0;
      pos = 0;
      r8_mode = 1'b1;
      for (int k = 0; k < 2 * FRAME; k++) tick_check();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule